// File: doc/BRIEF.md
# Pipelined SPI ADC Channel Sequencer

This block is the master side of a serial link to a multi-channel successive-approximation converter whose every conversion is set up by a 14-bit configuration word. The converter works as a pipeline. The word sent in one SPI frame sets up a conversion whose result is shifted back two frames later. The controller takes a channel number on a valid/ready port and keeps a shadow copy of the configuration word. It works out how many configuration frames are needed before the frame that carries the wanted result. It then returns that result with a one-cycle done strobe and the channel it belongs to.

After reset the controller runs a fixed startup sequence by itself. It sends one full configuration frame and then makes two channel-0 reads whose results are thrown away. A second port loads a whole new configuration word, which goes out in a single frame. The serial clock comes from the system clock through a divider. A minimum idle gap follows every frame. Frame width (14 or 16 bits), result resolution (14 or 16 bits), divider, gap length and reference code are parameters.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `req_ready` stays low until five startup frames have been sent. The first frame carries the full boot word: update flag bit 13 = 1, input mode bits 12:10 = 7, channel bits 9:7 = 0, bandwidth bit 6 = 1, reference bits 5:3 = REF_CODE, sequencer bits 2:1 = 0, bit 0 = 1. With REF_CODE = 1 this is 0x3C49. The frames that follow are configuration, data, configuration, data. `res_done` is never raised during startup.
- R2: A configuration frame shifts out the shadow word MSB first, left-aligned in the frame and padded with zeros at the low end (0x3C49 becomes 0xF124 in a 16-bit frame). A data frame shifts out all zeros.
- R3: A read of the same channel as the last completed read uses exactly two frames: one configuration frame, then one data frame.
- R4: A read of a different channel uses exactly three frames: two configuration frames, then one data frame.
- R5: `res_data` holds the top RES bits of the word received in the data frame, which is the received word shifted right by FRAME_BITS − RES. `res_chan` holds the channel that was requested.
- R6: A read changes only the channel field (bits 9:7) of the shadow word. All other bits keep their last written values.
- R7: A write on the configuration port sends exactly one frame, which carries the new word. The shadow copy is replaced by that word, and `res_done` is not raised.
- R8: Between a rising edge of `spi_cs_n` and the next falling edge there are at least GAP_CYC system clock cycles.
- R9: `spi_cs_n` stays low for exactly 2·FRAME_BITS·CLK_DIV cycles per frame. `spi_sclk` is low whenever `spi_cs_n` is high (SPI mode 0).
- R10: `req_ready` drops in the cycle after a request is accepted. `res_done` rises exactly one cycle after the rising edge of `spi_cs_n` that ends the data frame.
- R11: The channel remembered for the same-channel test starts at 0 after reset. So the first read of channel 0 after startup uses two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Channel read request valid |
| req_chan | input | 3 | Channel number to read |
| req_ready | output | 1 | Read request can be accepted |
| wr_valid | input | 1 | Full configuration write valid (has priority over a read) |
| wr_cfg | input | 14 | Configuration word to load |
| wr_ready | output | 1 | Configuration write can be accepted |
| res_done | output | 1 | One-cycle strobe: a result is available |
| res_data | output | RES | Conversion result |
| res_chan | output | 3 | Channel of the result |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |

## Verification
The bench models the converter with its two-frame lag. It records every frame's MOSI word, low time, idle gap and end cycle on the falling clock edge. The done strobe is due exactly one cycle after chip select rises at the end of the data frame. The bench stamps that rise and requires `res_done` to appear at stamp + 1. Frame counts and words are compared only after the strobe, or after `wr_ready` returns. Ready is checked one cycle after acceptance. All samples are taken one time unit after the falling edge, so that the registered outputs have settled.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CFG_W  = 14;
    localparam int CHAN_W = 3;

    // Field order is the converter's bit layout, MSB first
    typedef struct packed {
        logic              upd;
        logic [2:0]        mode;
        logic [CHAN_W-1:0] chan;
        logic              full_bw;
        logic [2:0]        refsel;
        logic [1:0]        seq;
        logic              rb_off;
    } cfg_t;

    typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT} seq_st_t;
    typedef enum logic [1:0] {FE_IDLE, FE_SHIFT, FE_GAP}  fe_st_t;

    function automatic cfg_t boot_cfg(input logic [2:0] code);
        cfg_t c;
        c.upd     = 1'b1;
        c.mode    = 3'd7;
        c.chan    = '0;
        c.full_bw = 1'b1;
        c.refsel  = code;
        c.seq     = 2'd0;
        c.rb_off  = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/adc_cfg_shadow.sv
module adc_cfg_shadow
    import adc_seq_pkg::*;
#(
    parameter int REF_CODE = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_full,
    input  cfg_t              full_val,
    input  logic              ld_chan,
    input  logic [CHAN_W-1:0] chan,
    output cfg_t              cfg
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= boot_cfg(3'(REF_CODE));
        else if (ld_full)
            cfg <= full_val;
        else if (ld_chan)
            cfg.chan <= chan;
    end

endmodule

// File: rtl/adc_spi_frame.sv
module adc_spi_frame
    import adc_seq_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int RX_BITS    = 14,
    parameter int CLK_DIV    = 2,
    parameter int GAP_CYC    = 20
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] tx_word,
    output logic                  ready,
    output logic                  done,
    output logic [RX_BITS-1:0]    rx_word,
    output logic                  cs_n,
    output logic                  sclk,
    output logic                  mosi,
    input  logic                  miso
);

    localparam int DIV_W     = $clog2(CLK_DIV + 1);
    localparam int BIT_W     = $clog2(FRAME_BITS + 1);
    localparam int GAP_W     = $clog2(GAP_CYC + 1);
    localparam int FRAME_CYC = 2 * FRAME_BITS * CLK_DIV;
    localparam int LOW_W     = $clog2(FRAME_CYC + 2);

    fe_st_t                st;
    logic [DIV_W-1:0]      div;
    logic [BIT_W-1:0]      bitc;
    logic [GAP_W-1:0]      gapc;
    logic [FRAME_BITS-1:0] shtx;
    logic [FRAME_BITS-1:0] shrx;

    assign ready = (st == FE_IDLE);
    assign mosi  = cs_n ? 1'b0 : shtx[FRAME_BITS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= FE_IDLE;
            cs_n    <= 1'b1;
            sclk    <= 1'b0;
            div     <= '0;
            bitc    <= '0;
            gapc    <= '0;
            shtx    <= '0;
            shrx    <= '0;
            done    <= 1'b0;
            rx_word <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                FE_IDLE: if (start) begin
                    shtx <= tx_word;
                    cs_n <= 1'b0;
                    div  <= '0;
                    bitc <= '0;
                    st   <= FE_SHIFT;
                end
                FE_SHIFT: if (div == DIV_W'(CLK_DIV - 1)) begin
                    div <= '0;
                    if (!sclk) begin
                        sclk <= 1'b1;
                        shrx <= {shrx[FRAME_BITS-2:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bitc == BIT_W'(FRAME_BITS - 1)) begin
                            cs_n    <= 1'b1;
                            done    <= 1'b1;
                            rx_word <= shrx[FRAME_BITS-1 -: RX_BITS];
                            gapc    <= '0;
                            st      <= FE_GAP;
                        end else begin
                            bitc <= bitc + 1'b1;
                            shtx <= {shtx[FRAME_BITS-2:0], 1'b0};
                        end
                    end
                end else begin
                    div <= div + 1'b1;
                end
                FE_GAP: if (gapc == GAP_W'(GAP_CYC - 1))
                    st <= FE_IDLE;
                else
                    gapc <= gapc + 1'b1;
                default: st <= FE_IDLE;
            endcase
        end
    end

    // Checker counters: cycles spent low and high on chip select
    logic [LOW_W-1:0] chk_low;
    logic [GAP_W:0]   chk_high;
    always_ff @(posedge clk) begin
        if (rst) begin
            chk_low  <= '0;
            chk_high <= (GAP_W+1)'(GAP_CYC);
        end else begin
            chk_low  <= cs_n ? '0 : chk_low + 1'b1;
            if (!cs_n)
                chk_high <= '0;
            else if (chk_high != (GAP_W+1)'(GAP_CYC))
                chk_high <= chk_high + 1'b1;
        end
    end

    AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);                                        // R9
    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> chk_low == LOW_W'(FRAME_CYC));          // R9
    AST_GAP_MIN: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> chk_high >= (GAP_W+1)'(GAP_CYC));       // R8

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int RES        = 14,
    parameter int CLK_DIV    = 2,
    parameter int GAP_CYC    = 20,
    parameter int REF_CODE   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_chan,
    output logic              req_ready,
    input  logic              wr_valid,
    input  logic [13:0]       wr_cfg,
    output logic              wr_ready,
    output logic              res_done,
    output logic [RES-1:0]    res_data,
    output logic [2:0]        res_chan,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    localparam int          TX_SHIFT = FRAME_BITS - CFG_W;
    localparam logic [1:0]  BOOT_OPS = 2'd3;

    seq_st_t           sq;
    logic [1:0]        cfg_left;
    logic              data_pend;
    logic              discard;
    logic [1:0]        boot_cnt;
    logic [CHAN_W-1:0] last_chan;
    logic [CHAN_W-1:0] cur_chan;
    logic              boot_done;
    logic              acc_wr, acc_rd;

    cfg_t                  shadow;
    logic [FRAME_BITS-1:0] tx_cfg;
    logic                  eng_start, eng_ready, eng_done;
    logic [RES-1:0]        eng_rx;

    assign boot_done = (boot_cnt == BOOT_OPS);
    assign wr_ready  = (sq == SQ_IDLE) && boot_done;
    assign req_ready = wr_ready && !wr_valid;
    assign acc_wr    = wr_ready && wr_valid;
    assign acc_rd    = req_ready && req_valid;
    assign eng_start = (sq == SQ_ISSUE) && eng_ready;

    generate
        if (TX_SHIFT == 0) begin : g_tx_flat
            assign tx_cfg = shadow;
        end else begin : g_tx_pad
            assign tx_cfg = {shadow, {TX_SHIFT{1'b0}}};
        end
    endgenerate

    adc_cfg_shadow #(.REF_CODE(REF_CODE)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .ld_full  (acc_wr),
        .full_val (cfg_t'(wr_cfg)),
        .ld_chan  (acc_rd),
        .chan     (req_chan),
        .cfg      (shadow)
    );

    adc_spi_frame #(
        .FRAME_BITS (FRAME_BITS),
        .RX_BITS    (RES),
        .CLK_DIV    (CLK_DIV),
        .GAP_CYC    (GAP_CYC)
    ) u_frame (
        .clk     (clk),
        .rst     (rst),
        .start   (eng_start),
        .tx_word ((cfg_left != 2'd0) ? tx_cfg : '0),
        .ready   (eng_ready),
        .done    (eng_done),
        .rx_word (eng_rx),
        .cs_n    (spi_cs_n),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .miso    (spi_miso)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sq        <= SQ_IDLE;
            cfg_left  <= '0;
            data_pend <= 1'b0;
            discard   <= 1'b0;
            boot_cnt  <= '0;
            last_chan <= '0;
            cur_chan  <= '0;
            res_done  <= 1'b0;
            res_data  <= '0;
            res_chan  <= '0;
        end else begin
            res_done <= 1'b0;
            case (sq)
                SQ_IDLE: begin
                    if (!boot_done) begin
                        boot_cnt <= boot_cnt + 1'b1;
                        cur_chan <= '0;
                        discard  <= 1'b1;
                        sq       <= SQ_ISSUE;
                        if (boot_cnt == 2'd0) begin
                            cfg_left  <= 2'd1;
                            data_pend <= 1'b0;
                        end else begin
                            cfg_left  <= (last_chan == '0) ? 2'd1 : 2'd2;
                            data_pend <= 1'b1;
                        end
                    end else if (acc_wr) begin
                        cfg_left  <= 2'd1;
                        data_pend <= 1'b0;
                        sq        <= SQ_ISSUE;
                    end else if (acc_rd) begin
                        cfg_left  <= (req_chan == last_chan) ? 2'd1 : 2'd2;
                        data_pend <= 1'b1;
                        discard   <= 1'b0;
                        cur_chan  <= req_chan;
                        sq        <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: if (eng_ready) sq <= SQ_WAIT;
                SQ_WAIT: if (eng_done) begin
                    if (cfg_left != 2'd0) begin
                        cfg_left <= cfg_left - 1'b1;
                        sq <= (cfg_left > 2'd1 || data_pend) ? SQ_ISSUE : SQ_IDLE;
                    end else begin
                        data_pend <= 1'b0;
                        last_chan <= cur_chan;
                        sq        <= SQ_IDLE;
                        if (!discard) begin
                            res_done <= 1'b1;
                            res_data <= eng_rx;
                            res_chan <= cur_chan;
                        end
                    end
                end
                default: sq <= SQ_IDLE;
            endcase
        end
    end

    AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);                          // R10
    AST_DONE_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
        res_done |-> $past(eng_done));                                     // R10
    AST_READ_KEEPS_FIELDS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=>
        ({shadow.upd, shadow.mode, shadow.full_bw, shadow.refsel, shadow.seq, shadow.rb_off}
         == $past({shadow.upd, shadow.mode, shadow.full_bw, shadow.refsel, shadow.seq, shadow.rb_off}))); // R6
    AST_NO_DONE_IN_BOOT: assert property (@(posedge clk) disable iff (rst)
        !boot_done |-> !res_done);                                         // R1

endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int FB         = 16;
    localparam int RESB       = 14;
    localparam int DIV        = 2;
    localparam int GAP        = 20;
    localparam int FRAME_CYC  = 2 * FB * DIV;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [2:0] req_chan = '0;
    logic req_ready;
    logic wr_valid = 1'b0;
    logic [13:0] wr_cfg = '0;
    logic wr_ready;
    logic res_done;
    logic [RESB-1:0] res_data;
    logic [2:0] res_chan;
    logic spi_cs_n, spi_sclk, spi_mosi;
    logic spi_miso = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_ctrl #(.FRAME_BITS(FB), .RES(RESB), .CLK_DIV(DIV), .GAP_CYC(GAP), .REF_CODE(1)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan), .req_ready(req_ready),
        .wr_valid(wr_valid), .wr_cfg(wr_cfg), .wr_ready(wr_ready), .res_done(res_done),
        .res_data(res_data), .res_chan(res_chan), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int nchk = 0;
    int nerr = 0;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [13:0] code_of(input int ch);
        return 14'h0400 + 14'(ch) * 14'h0123;
    endfunction

    // Converter model and frame monitor
    logic [15:0] frame_word [0:255];
    int          chan_after [0:255];
    logic [13:0] mcfg = '0;
    int nframes = 0, done_cnt = 0, cyc = 0, end_stamp = 0;
    int lowcnt = 0, gapcnt = 1000;
    logic p_cs = 1'b1, p_sclk = 1'b0, idle_bad = 1'b0;
    logic [15:0] rxw = '0, owd = '0;

    always @(negedge clk) begin
        cyc++;
        if (res_done) done_cnt++;
        if (!rst) begin
            if (p_cs && !spi_cs_n) begin
                chk(gapcnt >= GAP, "R8 gap", 32'(gapcnt), 32'(GAP));
                owd = {code_of(nframes >= 2 ? chan_after[nframes-2] : 0), 2'b11};
                spi_miso = owd[15];
                lowcnt = 1;
                rxw = '0;
            end else if (!spi_cs_n) lowcnt++;
            if (!spi_cs_n && spi_sclk && !p_sclk) rxw = {rxw[14:0], spi_mosi};
            if (!spi_cs_n && !spi_sclk && p_sclk) begin
                owd = {owd[14:0], 1'b0};
                spi_miso = owd[15];
            end
            if (spi_cs_n && !p_cs) begin
                chk(lowcnt == FRAME_CYC, "R9 cs low", 32'(lowcnt), 32'(FRAME_CYC));
                chk(!idle_bad, "R9 sclk idle low", 32'(idle_bad), 0);
                frame_word[nframes] = rxw;
                if (rxw[15]) mcfg = rxw[15:2];
                chan_after[nframes] = int'(mcfg[9:7]);
                nframes++;
                end_stamp = cyc;
                gapcnt = 0;
            end
            if (spi_cs_n) begin
                gapcnt++;
                if (spi_sclk) idle_bad = 1'b1;
            end
        end
        p_cs = spi_cs_n;
        p_sclk = spi_sclk;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    logic [13:0] exp_cfg = 14'h3C49;

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) step();
        chk(spi_cs_n == 1'b1, "R1 reset cs", 32'(spi_cs_n), 1);
        chk(spi_sclk == 1'b0, "R1 reset sclk", 32'(spi_sclk), 0);
        chk(req_ready == 1'b0, "R1 reset ready", 32'(req_ready), 0);
        chk(res_done == 1'b0, "R1 reset done", 32'(res_done), 0);
        rst = 1'b0;
    endtask

    task automatic t_startup();
        step();
        chk(req_ready == 1'b0, "R1 ready low in boot", 32'(req_ready), 0);
        while (!req_ready) step();
        chk(nframes == 5, "R1 boot frames", 32'(nframes), 5);
        chk(frame_word[0] == 16'hF124, "R1 boot word", 32'(frame_word[0]), 32'hF124);
        chk(frame_word[1] == 16'hF124, "R2 cfg frame", 32'(frame_word[1]), 32'hF124);
        chk(frame_word[2] == 16'h0000, "R2 data frame zero", 32'(frame_word[2]), 0);
        chk(frame_word[3] == 16'hF124, "R2 cfg frame", 32'(frame_word[3]), 32'hF124);
        chk(frame_word[4] == 16'h0000, "R2 data frame zero", 32'(frame_word[4]), 0);
        chk(done_cnt == 0, "R1 no done in boot", 32'(done_cnt), 0);
    endtask

    task automatic t_read(input int ch, input int exp_frames, input string rq);
        int f0, n;
        while (!req_ready) step();
        f0 = nframes;
        req_valid = 1'b1;
        req_chan = 3'(ch);
        step();
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10 ready drops", 32'(req_ready), 0);
        n = 0;
        while (!res_done && n < 20000) begin step(); n++; end
        chk(cyc == end_stamp + 1, "R10 done latency", 32'(cyc - end_stamp), 1);
        chk(res_data == code_of(ch), "R5 result", 32'(res_data), 32'(code_of(ch)));
        chk(res_chan == 3'(ch), "R5 channel", 32'(res_chan), 32'(ch));
        chk(nframes - f0 == exp_frames, rq, 32'(nframes - f0), 32'(exp_frames));
        exp_cfg[9:7] = 3'(ch);
        for (int i = 0; i < exp_frames - 1; i++) begin
            chk(frame_word[f0+i] == {exp_cfg, 2'b00}, "R2 cfg word",
                32'(frame_word[f0+i]), 32'({exp_cfg, 2'b00}));
            chk((frame_word[f0+i][15:2] & ~14'h0380) == (exp_cfg & ~14'h0380), "R6 other fields",
                32'(frame_word[f0+i][15:2]), 32'(exp_cfg));
        end
        chk(frame_word[f0+exp_frames-1] == 16'h0, "R2 data word zero",
            32'(frame_word[f0+exp_frames-1]), 0);
    endtask

    task automatic t_write(input logic [13:0] val);
        int f0, d0, n;
        while (!wr_ready) step();
        f0 = nframes;
        d0 = done_cnt;
        wr_valid = 1'b1;
        wr_cfg = val;
        step();
        wr_valid = 1'b0;
        n = 0;
        while (!wr_ready && n < 20000) begin step(); n++; end
        chk(nframes - f0 == 1, "R7 write frames", 32'(nframes - f0), 1);
        chk(frame_word[f0] == {val, 2'b00}, "R7 write word", 32'(frame_word[f0]), 32'({val, 2'b00}));
        chk(done_cnt == d0, "R7 no done on write", 32'(done_cnt - d0), 0);
        exp_cfg = val;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        t_reset();
        t_startup();
        t_read(0, 2, "R11 first read ch0 frames");
        t_read(0, 2, "R3 same channel frames");
        t_read(5, 3, "R4 new channel frames");
        t_read(5, 2, "R3 same channel frames");
        t_read(3, 3, "R4 new channel frames");
        t_write(14'h2E3D);
        t_read(6, 3, "R4 read after write frames");
        t_read(6, 2, "R3 same channel frames");
        t_read(7, 3, "R4 new channel frames");
        repeat (5) step();
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule